// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block holds the two interrupt flags that let two processors sharing a two-port memory signal each other. Each side owns one reserved "outgoing" mailbox address near the top of the address space. A write by one side to its outgoing address raises the interrupt toward the other side. When the other side reads that same address, it acknowledges the message and the flag drops. The accesses themselves still reach the memory as ordinary locations. This block only observes them and produces the two active-low interrupt lines.

The left port's outgoing address is the top address (all ones, 0x7FFF at the default 15-bit width). The right port's outgoing address is the one just below it (0x7FFE). Each flag is a small two-state machine with the states FLG_CLEAR and FLG_RAISED.

The machine has three transitions:
- RAISE moves FLG_CLEAR to FLG_RAISED on a qualified set.
- ACK moves FLG_RAISED to FLG_CLEAR on a qualified clear when no set is present.
- HOLD keeps the state in every other case.

A per-port busy input, active low, suppresses that port's set or clear action. The design is synchronous: accesses are sampled on the rising clock edge, and the interrupt output changes right after that edge.

Top module: `mbox_irq_pair`

## Requirements
- R1: A qualified left write (lft_cs_n=0, lft_we_n=0, lft_addr=0x7FFF, lft_busy_n=1) makes rgt_irq_n low after the next rising edge.
- R2: A qualified right read (rgt_cs_n=0, rgt_we_n=1, rgt_oe_n=0, rgt_addr=0x7FFF, rgt_busy_n=1) makes rgt_irq_n high after the next rising edge, unless R7 applies.
- R3: A qualified right write to 0x7FFE makes lft_irq_n low after the next rising edge.
- R4: A qualified left read of 0x7FFE makes lft_irq_n high after the next rising edge, unless R7 applies.
- R5: While the acting port's busy input is low, its write or read of a mailbox address leaves the flag unchanged.
- R6: With rst high at a rising edge, both lft_irq_n and rgt_irq_n are high after that edge.
- R7: When a qualified set and a qualified clear of the same flag fall in the same cycle, the flag ends up raised (output low).
- R8: A port reading its own outgoing address does not clear the flag it raised. Accesses to other addresses, or with chip enable high, also leave both flags unchanged.
- R9: A write qualifies regardless of output enable. A cycle with chip enable low and both read/write and output enable low is a write, never a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lft_cs_n | input | 1 | Left chip enable, active low |
| lft_we_n | input | 1 | Left read/write, low means write |
| lft_oe_n | input | 1 | Left output enable, active low |
| lft_addr | input | ADDR_W | Left address |
| lft_busy_n | input | 1 | Left busy, low suppresses left flag actions |
| lft_irq_n | output | 1 | Interrupt toward left processor, active low |
| rgt_cs_n | input | 1 | Right chip enable, active low |
| rgt_we_n | input | 1 | Right read/write, low means write |
| rgt_oe_n | input | 1 | Right output enable, active low |
| rgt_addr | input | ADDR_W | Right address |
| rgt_busy_n | input | 1 | Right busy, low suppresses right flag actions |
| rgt_irq_n | output | 1 | Interrupt toward right processor, active low |

## Verification
A raise from one port and an acknowledge from the other port can land on the same flag in the same cycle. This happens when the left port writes 0x7FFF while the right port reads 0x7FFF, and likewise for the mirror case on 0x7FFE. The bench provokes this collision directly, with the flag both already raised and still clear. It also reaches the collision often under random stimulus biased toward the two mailbox addresses. Each collision is judged against a bench model in which the set wins, including cases where busy on one side removes one of the two competing actions.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int PORTS = 2;

    typedef enum logic {
        FLG_CLEAR  = 1'b0,
        FLG_RAISED = 1'b1
    } flag_state_t;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
    parameter int                ADDR_W   = 15,
    parameter logic [ADDR_W-1:0] OUT_ADDR = '1,
    parameter logic [ADDR_W-1:0] IN_ADDR  = '0
) (
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    output logic              raise_o,
    output logic              ack_o
);
    logic wr_cyc;
    logic rd_cyc;

    always_comb begin
        // R9: a write ignores output enable; a read needs we_n high
        wr_cyc  = !cs_n && !we_n;
        rd_cyc  = !cs_n && we_n && !oe_n;
        // R5: busy low blocks this port's actions
        raise_o = wr_cyc && busy_n && (addr == OUT_ADDR);
        // R8: only the incoming address acknowledges
        ack_o   = rd_cyc && busy_n && (addr == IN_ADDR);
    end
endmodule

// File: rtl/mbox_flag_fsm.sv
module mbox_flag_fsm
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raise_i,
    input  logic ack_i,
    output logic irq_n_o
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: begin
                if (raise_i) state_d = FLG_RAISED;          // RAISE
            end
            FLG_RAISED: begin
                if (ack_i && !raise_i) state_d = FLG_CLEAR; // ACK, set wins (R7)
            end
            default: state_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FLG_CLEAR;                      // R6
        else     state_q <= state_d;
    end

    always_comb begin
        irq_n_o = (state_q != FLG_RAISED);
    end
endmodule

// File: rtl/mbox_irq_pair.sv
module mbox_irq_pair
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lft_cs_n,
    input  logic              lft_we_n,
    input  logic              lft_oe_n,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              lft_busy_n,
    output logic              lft_irq_n,
    input  logic              rgt_cs_n,
    input  logic              rgt_we_n,
    input  logic              rgt_oe_n,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic              rgt_busy_n,
    output logic              rgt_irq_n
);
    localparam logic [ADDR_W-1:0] MBOX_TOP  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] MBOX_NEXT = MBOX_TOP - ADDR_W'(1);

    logic              cs_n_v   [PORTS];
    logic              we_n_v   [PORTS];
    logic              oe_n_v   [PORTS];
    logic [ADDR_W-1:0] addr_v   [PORTS];
    logic              busy_n_v [PORTS];
    logic              raise_v  [PORTS];
    logic              ack_v    [PORTS];
    logic              irq_n_v  [PORTS];

    always_comb begin
        cs_n_v[0]   = lft_cs_n;   cs_n_v[1]   = rgt_cs_n;
        we_n_v[0]   = lft_we_n;   we_n_v[1]   = rgt_we_n;
        oe_n_v[0]   = lft_oe_n;   oe_n_v[1]   = rgt_oe_n;
        addr_v[0]   = lft_addr;   addr_v[1]   = rgt_addr;
        busy_n_v[0] = lft_busy_n; busy_n_v[1] = rgt_busy_n;
    end

    // Port 0 is left, port 1 is right
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] OUT_A = (p == 0) ? MBOX_TOP  : MBOX_NEXT;
        localparam logic [ADDR_W-1:0] IN_A  = (p == 0) ? MBOX_NEXT : MBOX_TOP;

        mbox_port_decode #(
            .ADDR_W   (ADDR_W),
            .OUT_ADDR (OUT_A),
            .IN_ADDR  (IN_A)
        ) u_dec (
            .cs_n    (cs_n_v[p]),
            .we_n    (we_n_v[p]),
            .oe_n    (oe_n_v[p]),
            .addr    (addr_v[p]),
            .busy_n  (busy_n_v[p]),
            .raise_o (raise_v[p]),
            .ack_o   (ack_v[p])
        );

        // Flag p interrupts port p: raised by the far port, acknowledged locally
        mbox_flag_fsm u_flag (
            .clk     (clk),
            .rst     (rst),
            .raise_i (raise_v[PORTS-1-p]),
            .ack_i   (ack_v[p]),
            .irq_n_o (irq_n_v[p])
        );
    end

    assign lft_irq_n = irq_n_v[0];
    assign rgt_irq_n = irq_n_v[1];
endmodule

// File: rtl/mbox_irq_pair_chk.sv
module mbox_irq_pair_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              lft_cs_n,
    input logic              lft_we_n,
    input logic              lft_oe_n,
    input logic [ADDR_W-1:0] lft_addr,
    input logic              lft_busy_n,
    input logic              lft_irq_n,
    input logic              rgt_cs_n,
    input logic              rgt_we_n,
    input logic              rgt_oe_n,
    input logic [ADDR_W-1:0] rgt_addr,
    input logic              rgt_busy_n,
    input logic              rgt_irq_n
);
    localparam logic [ADDR_W-1:0] TOP_A = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NXT_A = TOP_A - ADDR_W'(1);

    logic l_wr_top, l_rd_nxt, r_wr_nxt, r_rd_top;

    always_comb begin
        l_wr_top = !lft_cs_n && !lft_we_n && lft_addr == TOP_A;
        l_rd_nxt = !lft_cs_n && lft_we_n && !lft_oe_n && lft_addr == NXT_A;
        r_wr_nxt = !rgt_cs_n && !rgt_we_n && rgt_addr == NXT_A;
        r_rd_top = !rgt_cs_n && rgt_we_n && !rgt_oe_n && rgt_addr == TOP_A;
    end

    a_r6_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (lft_irq_n && rgt_irq_n));

    a_r1_left_sets_right: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(l_wr_top && lft_busy_n)) |-> !rgt_irq_n);

    a_r3_right_sets_left: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(r_wr_nxt && rgt_busy_n)) |-> !lft_irq_n);

    a_r2_right_clears: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(r_rd_top && rgt_busy_n && !(l_wr_top && lft_busy_n)))
        |-> rgt_irq_n);

    a_r4_left_clears: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(l_rd_nxt && lft_busy_n && !(r_wr_nxt && rgt_busy_n)))
        |-> lft_irq_n);

    a_r5_busy_blocks_right_flag: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!lft_busy_n && !(r_rd_top && rgt_busy_n)))
        |-> $stable(rgt_irq_n));

    a_r5_busy_blocks_left_flag: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!rgt_busy_n && !(l_rd_nxt && lft_busy_n)))
        |-> $stable(lft_irq_n));
endmodule

bind mbox_irq_pair mbox_irq_pair_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst),
    .lft_cs_n(lft_cs_n), .lft_we_n(lft_we_n), .lft_oe_n(lft_oe_n),
    .lft_addr(lft_addr), .lft_busy_n(lft_busy_n), .lft_irq_n(lft_irq_n),
    .rgt_cs_n(rgt_cs_n), .rgt_we_n(rgt_we_n), .rgt_oe_n(rgt_oe_n),
    .rgt_addr(rgt_addr), .rgt_busy_n(rgt_busy_n), .rgt_irq_n(rgt_irq_n)
);

// File: tb/mbox_irq_pair_tb.sv
`timescale 1ns/1ps
module mbox_irq_pair_tb;
    localparam int AW = 15;
    localparam logic [AW-1:0] TOP_A = 15'h7FFF;
    localparam logic [AW-1:0] NXT_A = 15'h7FFE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lcs, lwe, loe, lbusy, rcs, rwe, roe, rbusy;
    logic [AW-1:0] laddr, raddr;
    logic lirq, rirq;
    logic exp_l, exp_r;   // expected raised state
    int   errs = 0;
    int   checks = 0;
    int   cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mbox_irq_pair #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .lft_cs_n(lcs), .lft_we_n(lwe), .lft_oe_n(loe), .lft_addr(laddr),
        .lft_busy_n(lbusy), .lft_irq_n(lirq),
        .rgt_cs_n(rcs), .rgt_we_n(rwe), .rgt_oe_n(roe), .rgt_addr(raddr),
        .rgt_busy_n(rbusy), .rgt_irq_n(rirq)
    );

    function automatic logic is_wr(logic cs, logic we, logic [AW-1:0] a,
                                   logic busy, logic [AW-1:0] tgt);
        return !cs && !we && busy && a == tgt;
    endfunction

    function automatic logic is_rd(logic cs, logic we, logic oe, logic [AW-1:0] a,
                                   logic busy, logic [AW-1:0] tgt);
        return !cs && we && !oe && busy && a == tgt;
    endfunction

    function automatic logic nxt(logic cur, logic set, logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction

    task automatic drive(logic a_cs, logic a_we, logic a_oe, logic [AW-1:0] a_ad, logic a_bz,
                         logic b_cs, logic b_we, logic b_oe, logic [AW-1:0] b_ad, logic b_bz);
        lcs = a_cs; lwe = a_we; loe = a_oe; laddr = a_ad; lbusy = a_bz;
        rcs = b_cs; rwe = b_we; roe = b_oe; raddr = b_ad; rbusy = b_bz;
    endtask

    task automatic compare(string tag);
        checks++;
        if (lirq !== !exp_l || rirq !== !exp_r) begin
            errs++;
            $display("FAIL %s: lft_irq_n=%b rgt_irq_n=%b expected %b %b",
                     tag, lirq, rirq, !exp_l, !exp_r);
        end
    endtask

    // Drive at negedge, clock one edge, compare at the following negedge
    task automatic step(string tag);
        logic sr, cr, sl, cl;
        sr = is_wr(lcs, lwe, laddr, lbusy, TOP_A);
        cr = is_rd(rcs, rwe, roe, raddr, rbusy, TOP_A);
        sl = is_wr(rcs, rwe, raddr, rbusy, NXT_A);
        cl = is_rd(lcs, lwe, loe, laddr, lbusy, NXT_A);
        @(posedge clk);
        if (rst) begin exp_l = 1'b0; exp_r = 1'b0; end
        else begin exp_l = nxt(exp_l, sl, cl); exp_r = nxt(exp_r, sr, cr); end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        drive(1, 1, 1, '0, 1, 1, 1, 1, '0, 1);
    endtask

    initial begin
        #200000;
        errs++; checks++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        exp_l = 0; exp_r = 0;
        idle();
        rst = 1;
        @(negedge clk);
        step("R6 reset");
        rst = 0;
        idle(); step("R8 idle");
        // R1 then R2
        drive(0, 0, 1, TOP_A, 1, 1, 1, 1, '0, 1); step("R1 left sets right");
        idle(); step("R8 hold raised");
        drive(0, 1, 0, TOP_A, 1, 1, 1, 1, '0, 1); step("R8 own read no clear");
        drive(1, 1, 1, '0, 1, 0, 1, 0, TOP_A, 0); step("R5 busy blocks clear");
        drive(1, 1, 1, '0, 1, 0, 1, 0, TOP_A, 1); step("R2 right clears");
        // R3 then R4
        drive(1, 1, 1, '0, 1, 0, 0, 1, NXT_A, 0); step("R5 busy blocks set");
        drive(1, 1, 1, '0, 1, 0, 0, 0, NXT_A, 1); step("R9 write with oe low sets left R3");
        drive(0, 0, 0, NXT_A, 1, 1, 1, 1, '0, 1); step("R9 write not a clear");
        drive(0, 1, 0, NXT_A, 1, 1, 1, 1, '0, 1); step("R4 left clears");
        // R7 collisions
        drive(0, 0, 1, TOP_A, 1, 0, 1, 0, TOP_A, 1); step("R7 collide from clear");
        drive(0, 0, 1, TOP_A, 1, 0, 1, 0, TOP_A, 1); step("R7 collide while raised");
        drive(0, 1, 0, NXT_A, 1, 0, 0, 1, NXT_A, 1); step("R7 collide left flag");
        drive(1, 0, 0, NXT_A, 1, 1, 1, 0, TOP_A, 1); step("R8 cs high no effect");
        drive(0, 1, 0, 15'h1234, 1, 0, 1, 0, 15'h0FFF, 1); step("R8 other addr");
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a, b;
            int k;
            k = $urandom_range(0, 9);
            a = (k < 4) ? TOP_A : (k < 8) ? NXT_A : AW'($urandom);
            k = $urandom_range(0, 9);
            b = (k < 4) ? TOP_A : (k < 8) ? NXT_A : AW'($urandom);
            drive(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom), a,
                  1'($urandom_range(0, 4) != 0),
                  1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom), b,
                  1'($urandom_range(0, 4) != 0));
            rst = ($urandom_range(0, 99) == 0);
            step(rst ? "R6 random reset" : "R7 random mix");
        end
        rst = 0;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule